// File: doc/BRIEF.md
# Transport Stream Playback Packet Expander

This block sits on the playback path of a stored transport stream. It pulls bytes from a first-word-fall-through FIFO and drives a byte-parallel MPEG transport stream with a data-valid and a packet-start strobe. The recording side replaced every unwanted packet with a single 0xC7 placeholder byte. On playback, each placeholder that lands where a packet's sync byte belongs is expanded back into a full 188-byte null packet. The output therefore keeps the packet spacing of the original broadcast.

A modulo-188 position counter produces the start strobe. At position 0 the counter waits until it sees a 0x47 sync byte or a placeholder. Any other byte at that position is passed on without advancing the counter. After a misalignment, the stream therefore locks back onto packet boundaries within a few packets, with no outside help. Rate control is minimal: one byte goes out per clock whenever a byte is available, either from the FIFO or from the null generator.

Top module: `ts_pkt_expander`

## Requirements
- R1: `fifo_rd_en` is high only when `fifo_empty` is low. It is high in every cycle where the FIFO is not empty and no null packet is being generated. A high `fifo_rd_en` consumes the byte currently shown on `fifo_data`.
- R2: A byte consumed in cycle n appears on `ts_data` with `ts_valid` high after the next rising edge (one register of latency).
- R3: A 0xC7 byte read at position 0 produces 188 consecutive valid output bytes. The first four are 0x47, 0x1F, 0xFF, 0x10 (PID 0x1FFF, payload-only, continuity 0). The remaining 184 are 0xFF.
- R4: After the placeholder has been consumed, `fifo_rd_en` stays low for the other 187 bytes of the generated null packet.
- R5: `ts_start` is high exactly for the output byte that opens a packet, real or generated. That byte is always 0x47 with `ts_valid` high.
- R6: A 0xC7 byte at any position other than 0 is output unchanged, with `ts_start` low.
- R7: At position 0, a byte other than 0x47 or 0xC7 is output unchanged with `ts_start` low, and the position stays 0.
- R8: Once a packet opens, the position advances by one per output byte and wraps after 188 bytes. A 0x47 byte inside a packet does not raise `ts_start`.
- R9: When the FIFO is empty and no null packet is in progress, `ts_valid` and `ts_start` go low on the next edge and the position is held.
- R10: While `rst_n` is low, `fifo_rd_en` is low. After a reset edge, `ts_valid` and `ts_start` are low and the position is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_empty | input | 1 | FIFO has no byte to offer |
| fifo_data | input | 8 | Head byte of the FIFO (fall-through) |
| fifo_rd_en | output | 1 | Consume the head byte this cycle |
| ts_data | output | 8 | Output stream byte |
| ts_valid | output | 1 | `ts_data` carries a byte this cycle |
| ts_start | output | 1 | First byte of a packet |

## Verification
An error in the position counter or the null-packet flag shows at the ports within one packet. A counter off by one moves the next `ts_start` away from a 0x47 byte, or makes it appear inside a packet. A null flag that clears early or late makes `fifo_rd_en` rise during the 188-byte null window, or shortens or stretches the run of 0xFF bytes. The bench therefore compares the outputs and `fifo_rd_en` with a behavioural model on every cycle. Its stimulus includes misaligned leading bytes, sync-like and placeholder-like values inside packets, back-to-back placeholders, a truncated packet that forces a resynchronisation, and FIFO gaps in the middle of packets.

// File: rtl/ts_exp_pkg.sv
// Package: shared constants and types for the playback packet expander.
// Assumes a fixed-length 188-byte transport packet with an 8-bit data path.
package ts_exp_pkg;
    localparam int unsigned PKT_BYTES   = 188;
    localparam logic [7:0]  SYNC_VAL    = 8'h47;
    localparam logic [7:0]  HOLE_VAL    = 8'hC7;
    localparam logic [12:0] NULL_PID    = 13'h1FFF;
    localparam logic [7:0]  STUFF_VAL   = 8'hFF;

    typedef logic [7:0] byte_t;
endpackage

// File: rtl/ts_pos_tracker.sv
// Module: packet position counter plus the null-packet-in-progress flag.
// Advances once per emitted packet byte, wraps after PKT_LEN bytes and
// raises the null flag when a placeholder opens a packet. Assumes the
// caller only asserts 'advance' for bytes that belong to a packet.
module ts_pos_tracker #(
    parameter int unsigned PKT_LEN = 188,
    localparam int unsigned POS_W  = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             open_null,
    output logic [POS_W-1:0] pos,
    output logic             in_null
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

    logic at_last;
    assign at_last = (pos == LAST_POS);

    // Position counter: step on each packet byte, wrap at packet end.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos <= '0;
        else if (advance) pos <= at_last ? '0 : pos + 1'b1;
    end

    // Null flag: set by a placeholder, cleared after the last generated byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                      in_null <= 1'b0;
        else if (open_null)              in_null <= 1'b1;
        else if (in_null && at_last)     in_null <= 1'b0;
    end

    // R3: a generated packet never sits at position 0 (it owns 1..LAST).
    a_r3_null_not_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        in_null |-> (pos != '0));

    // R3: the null flag only drops after the last position of the packet.
    a_r3_null_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_null) |-> ($past(pos) == LAST_POS));

    // R8: stepping from the last position wraps to the packet head.
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && at_last) |=> (pos == '0));
endmodule

// File: rtl/ts_null_gen.sv
// Module: combinational source of null-packet bytes by packet position.
// Header carries the configured PID, payload-only adaptation control and
// continuity 0; every later byte is the stuffing value.
module ts_null_gen #(
    parameter int unsigned PKT_LEN = 188,
    parameter logic [7:0]  SYNC    = 8'h47,
    parameter logic [12:0] PID     = 13'h1FFF,
    parameter logic [7:0]  STUFF   = 8'hFF,
    localparam int unsigned POS_W  = $clog2(PKT_LEN)
) (
    input  logic [POS_W-1:0] pos,
    output logic [7:0]       gen_byte
);
    localparam logic [7:0] HDR1 = {3'b000, PID[12:8]};
    localparam logic [7:0] HDR2 = PID[7:0];
    localparam logic [7:0] HDR3 = 8'h10;

    // Header lookup for positions 0..3, stuffing elsewhere.
    always_comb begin
        case (pos)
            POS_W'(0): gen_byte = SYNC;
            POS_W'(1): gen_byte = HDR1;
            POS_W'(2): gen_byte = HDR2;
            POS_W'(3): gen_byte = HDR3;
            default:   gen_byte = STUFF;
        endcase
    end
endmodule

// File: rtl/ts_out_reg.sv
// Module: output register stage for the stream byte, valid and start.
// Assumes the caller presents a start only with a valid sync byte.
module ts_out_reg #(
    parameter logic [7:0] SYNC = 8'h47
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] nxt_data,
    input  logic       nxt_valid,
    input  logic       nxt_start,
    output logic [7:0] ts_data,
    output logic       ts_valid,
    output logic       ts_start
);
    // Register the outgoing byte and its qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_data  <= '0;
            ts_valid <= 1'b0;
            ts_start <= 1'b0;
        end else begin
            ts_data  <= nxt_data;
            ts_valid <= nxt_valid;
            ts_start <= nxt_start;
        end
    end

    // R5: a start strobe always marks a valid sync byte.
    a_r5_start_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ts_start |-> (ts_valid && ts_data == SYNC));
endmodule

// File: rtl/ts_pkt_expander.sv
// Module: top of the playback packet expander.
// Reads a fall-through FIFO, expands 0xC7 placeholders found at packet
// position 0 into full null packets, and strobes the first byte of each
// packet. Position 0 waits for a sync byte so alignment recovers by itself.
module ts_pkt_expander #(
    parameter int unsigned PKT_LEN  = ts_exp_pkg::PKT_BYTES,
    parameter logic [7:0]  SYNC     = ts_exp_pkg::SYNC_VAL,
    parameter logic [7:0]  HOLE     = ts_exp_pkg::HOLE_VAL,
    parameter logic [12:0] PID      = ts_exp_pkg::NULL_PID,
    parameter logic [7:0]  STUFF    = ts_exp_pkg::STUFF_VAL
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_rd_en,
    output logic [7:0] ts_data,
    output logic       ts_valid,
    output logic       ts_start
);
    localparam int unsigned POS_W = $clog2(PKT_LEN);

    logic [POS_W-1:0]  pos;
    logic              in_null;
    ts_exp_pkg::byte_t gen_byte;
    logic              take, at_head, is_sync, is_hole;
    logic              opens_pkt, open_null, advance;
    ts_exp_pkg::byte_t nxt_data;
    logic              nxt_valid;

    // Decode the FIFO head byte against the current packet position.
    always_comb begin
        take      = rst_n && !in_null && !fifo_empty;
        at_head   = (pos == '0);
        is_sync   = (fifo_data == SYNC);
        is_hole   = (fifo_data == HOLE);
        opens_pkt = take && at_head && (is_sync || is_hole);
        open_null = take && at_head && is_hole;
        advance   = in_null || (take && (!at_head || is_sync || is_hole));
    end

    // Pick the outgoing byte: generated, rewritten placeholder, or pass-through.
    always_comb begin
        if (in_null)        nxt_data = gen_byte;
        else if (open_null) nxt_data = SYNC;
        else                nxt_data = fifo_data;
        nxt_valid = in_null || take;
    end

    assign fifo_rd_en = take;

    ts_pos_tracker #(.PKT_LEN(PKT_LEN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .open_null (open_null),
        .pos       (pos),
        .in_null   (in_null)
    );

    ts_null_gen #(.PKT_LEN(PKT_LEN), .SYNC(SYNC), .PID(PID), .STUFF(STUFF)) u_gen (
        .pos      (pos),
        .gen_byte (gen_byte)
    );

    ts_out_reg #(.SYNC(SYNC)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_data  (nxt_data),
        .nxt_valid (nxt_valid),
        .nxt_start (opens_pkt),
        .ts_data   (ts_data),
        .ts_valid  (ts_valid),
        .ts_start  (ts_start)
    );

    // R1: never pop an empty FIFO.
    a_r1_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);

    // R4: no FIFO traffic while a null packet is being generated.
    a_r4_quiet_in_null: assert property (@(posedge clk) disable iff (!rst_n)
        in_null |-> !fifo_rd_en);

    // R9: an idle cycle holds the position and clears valid on the next edge.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !in_null) |=> ($stable(pos) && !ts_valid && !ts_start));

    // R7: a non-sync, non-placeholder byte at the head leaves position at 0.
    a_r7_head_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd_en && pos == '0 && fifo_data != SYNC && fifo_data != HOLE)
            |=> (pos == '0 && !ts_start));
endmodule

// File: tb/ts_pkt_expander_bench.sv
// Bench: behavioural model of the expander compared on every clock.
module ts_pkt_expander_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    logic       fifo_rd_en;
    logic [7:0] ts_data;
    logic       ts_valid;
    logic       ts_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_pkt_expander u_ts_pkt_expander (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd_en(fifo_rd_en), .ts_data(ts_data), .ts_valid(ts_valid), .ts_start(ts_start)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int null_byte(input int p);
        case (p)
            0: return 'h47;
            1: return 'h1F;
            2: return 'hFF;
            3: return 'h10;
            default: return 'hFF;
        endcase
    endfunction

    task automatic push_real(input int len, input int seed);
        q.push_back(8'h47);
        for (int i = 1; i < len; i++) begin
            if (i == 5)       q.push_back(8'hC7);   // R6 placeholder value mid-packet
            else if (i == 10) q.push_back(8'h47);   // R8 sync value mid-packet
            else              q.push_back(8'((i * 7 + seed) & 8'h3F));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int  mpos = 0;
        bit  mnull = 0;
        bit  have_exp = 0;
        bit  prev_take = 0;
        int  e_data = 0;
        bit  e_valid = 0, e_start = 0;
        string e_tag = "R2";
        int  cyc = 0;
        int  idle = 0;

        // Stimulus: misaligned lead-in, real packets, placeholders, truncation.
        q.push_back(8'h12); q.push_back(8'h00); q.push_back(8'h33);  // R7
        push_real(188, 1);
        q.push_back(8'hC7);                                          // R3
        push_real(188, 2);
        q.push_back(8'hC7); q.push_back(8'hC7);                      // back-to-back nulls
        push_real(100, 3);                                           // truncated
        push_real(188, 4);
        push_real(188, 5);
        push_real(188, 6);
        q.push_back(8'hC7);

        fifo_empty = 1'b0;
        fifo_data  = q[0];
        // R10: reset behaviour with data waiting.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "rd_en in reset", int'(fifo_rd_en), 0);
        check("R10", "valid after reset", int'(ts_valid), 0);
        check("R10", "start after reset", int'(ts_start), 0);
        rst_n = 1'b1;

        while (idle < 4) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            // Compare outputs produced by the last edge against the model.
            if (have_exp) begin
                check(e_tag, "ts_valid", int'(ts_valid), int'(e_valid));
                check("R5", "ts_start", int'(ts_start), int'(e_start));
                if (e_valid) check(e_tag, "ts_data", int'(ts_data), e_data);
            end
            if (prev_take) void'(q.pop_front());
            // FIFO gaps: mid-packet stalls during a window of the run (R9).
            fifo_empty = (q.size() == 0) || (cyc > 300 && cyc < 900 && (cyc % 7) == 3);
            fifo_data  = (q.size() != 0) ? q[0] : 8'h00;
            #1;
            // Model step for this cycle.
            e_start = 0;
            if (mnull) begin
                prev_take = 0;
                e_valid = 1; e_data = null_byte(mpos); e_tag = "R3";
                mpos++;
                if (mpos == 188) begin mpos = 0; mnull = 0; end
            end else if (!fifo_empty) begin
                logic [7:0] b;
                b = q[0];
                prev_take = 1; e_valid = 1;
                if (mpos == 0) begin
                    if (b == 8'h47) begin
                        e_data = 'h47; e_start = 1; e_tag = "R5"; mpos = 1;
                    end else if (b == 8'hC7) begin
                        e_data = 'h47; e_start = 1; e_tag = "R3"; mpos = 1; mnull = 1;
                    end else begin
                        e_data = int'(b); e_tag = "R7";
                    end
                end else begin
                    e_data = int'(b);
                    e_tag = (b == 8'hC7) ? "R6" : ((b == 8'h47) ? "R8" : "R2");
                    mpos = (mpos == 187) ? 0 : mpos + 1;
                end
            end else begin
                prev_take = 0; e_valid = 0; e_tag = "R9";
            end
            check(mnull && !prev_take && e_tag == "R3" ? "R4" : "R1", "fifo_rd_en",
                  int'(fifo_rd_en), int'(prev_take));
            have_exp = 1;
            if (q.size() == 0 && !mnull) idle++;
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule